// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-interrupt flags and turns them into interrupt requests for one 16-bit timer/counter. The timer has an input-capture channel, a parameterized number of output-compare channels (two by default) and overflow detection. The counter datapath feeds it event indications. The block samples them only on cycles where the timer-clock enable `tick` is high. The block latches each event into a flag and gates the flag with a per-source enable and a global interrupt enable. It then reports the highest-priority pending source.

Software clears a flag by writing a one to its bit. A vector unit clears a flag by pulsing that source's acknowledge line. Compare flags are delayed by one timer clock after the match. A forced-compare strobe never sets a compare flag. When the waveform mode uses the capture register as the counter's TOP, the capture flag follows the TOP-reached indication instead of the capture pin.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, every flag bit, every request, `irq_any` and `irq_id` are zero.
- R2: A compare channel whose match input is high on a `tick` cycle sets its flag at the next `tick` cycle and not earlier, however many non-tick cycles come between. Event inputs that arrive on a cycle with `tick` low have no effect.
- R3: If a channel's force strobe is high on the same `tick` cycle as its match, that match never sets the channel's flag.
- R4: With `cap_is_top` low, `cap_evt` on a tick sets the capture flag and `top_hit` is ignored. With `cap_is_top` high, `top_hit` on a tick sets it and `cap_evt` is ignored. In both cases the flag is set by the edge of that tick.
- R5: `ovf_evt` on a tick sets the overflow flag at the edge of that tick.
- R6: The flag layout is: bit 0 capture, bits 1..CMP_CH compare channels (bit 1 = channel A, bit 2 = channel B), and bit CMP_CH+1 overflow. A cycle with `wr_en` high clears every flag whose `wr_data` bit is one. Flags whose `wr_data` bit is zero keep their value.
- R7: A high `ack` bit clears the flag at the same position after that clock edge.
- R8: When a set event and a clear (by write or by acknowledge) reach the same flag in the same cycle, the flag ends up one.
- R9: `irq_req[i]` is high exactly when flag i, `irq_en[i]` and `gie` are all one. `irq_any` is the OR of `irq_req`.
- R10: `irq_id` gives the lowest-numbered active request: capture, then compare A, then compare B, then overflow. It is zero when no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable; events are sampled only when high |
| cmp_match | input | CMP_CH | Counter equals compare register, per channel |
| cmp_force | input | CMP_CH | Forced-compare strobe, per channel |
| cap_evt | input | 1 | Capture pin event |
| top_hit | input | 1 | Counter reached TOP |
| cap_is_top | input | 1 | Capture register serves as TOP; selects capture flag source |
| ovf_evt | input | 1 | Counter overflow event |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | CMP_CH+2 | Write data; ones clear flags |
| ack | input | CMP_CH+2 | Per-source vector acknowledge pulses |
| irq_en | input | CMP_CH+2 | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| flag_rd | output | CMP_CH+2 | Current flag register |
| irq_req | output | CMP_CH+2 | Per-source interrupt requests |
| irq_any | output | 1 | Combined interrupt request |
| irq_id | output | $clog2(CMP_CH+2) | Index of highest-priority request |

## Verification
The bench builds the block with its defaults: two compare channels and a match latency of one timer clock. That gives a four-bit flag register. With so few flags, every flag pattern can be crossed with every enable mask and both global-enable states, and every write-clear and acknowledge mask can be applied to a full register. The small latency lets the bench place compare matches next to gaps of non-tick cycles, forced strobes, and clears that land on the setting tick.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
package tmr_irq_pkg;

    // Sources ahead of and behind the compare channels in the flag word.
    localparam int unsigned FIXED_SRC = 2;
    localparam int unsigned CAP_POS   = 0;

    function automatic int unsigned flag_count(input int unsigned ch);
        return ch + FIXED_SRC;
    endfunction

    function automatic int unsigned ovf_pos(input int unsigned ch);
        return ch + 1;
    endfunction

    // Non-compare event strobes after tick qualification.
    typedef struct packed {
        logic cap;
        logic ovf;
    } fixed_set_t;

endpackage

// File: rtl/tmr_cmp_delay.sv
`timescale 1ns/1ps
module tmr_cmp_delay #(
    parameter int unsigned LAT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic match_i,
    input  logic force_i,
    output logic set_o
);
    logic [LAT-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else if (tick) begin
            stg_q[0] <= match_i & ~force_i;
            for (int k = 1; k < int'(LAT); k++) begin
                stg_q[k] <= stg_q[k-1];
            end
        end
    end

    assign set_o = tick & stg_q[LAT-1];
endmodule

// File: rtl/tmr_flag_cell.sv
`timescale 1ns/1ps
module tmr_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/tmr_irq_pick.sv
`timescale 1ns/1ps
module tmr_irq_pick #(
    parameter int unsigned N    = 4,
    parameter int unsigned ID_W = 2
) (
    input  logic [N-1:0]    pend_i,
    output logic            any_o,
    output logic [ID_W-1:0] id_o
);
    always_comb begin
        any_o = |pend_i;
        id_o  = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (pend_i[i]) id_o = ID_W'(i);
        end
    end
endmodule

// File: rtl/tmr_irq_flags.sv
`timescale 1ns/1ps
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int unsigned CMP_CH    = 2,
    parameter int unsigned MATCH_LAT = 1,
    localparam int unsigned NF       = flag_count(CMP_CH),
    localparam int unsigned ID_W     = $clog2(NF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CMP_CH-1:0] cmp_match,
    input  logic [CMP_CH-1:0] cmp_force,
    input  logic              cap_evt,
    input  logic              top_hit,
    input  logic              cap_is_top,
    input  logic              ovf_evt,
    input  logic              wr_en,
    input  logic [NF-1:0]     wr_data,
    input  logic [NF-1:0]     ack,
    input  logic [NF-1:0]     irq_en,
    input  logic              gie,
    output logic [NF-1:0]     flag_rd,
    output logic [NF-1:0]     irq_req,
    output logic              irq_any,
    output logic [ID_W-1:0]   irq_id
);
    localparam int unsigned OVF_IDX = ovf_pos(CMP_CH);

    fixed_set_t      fx;
    logic [NF-1:0]   set_v;
    logic [NF-1:0]   clr_v;

    always_comb begin
        fx.cap = tick & (cap_is_top ? top_hit : cap_evt);
        fx.ovf = tick & ovf_evt;
    end

    assign set_v[CAP_POS] = fx.cap;
    assign set_v[OVF_IDX] = fx.ovf;

    for (genvar g = 0; g < int'(CMP_CH); g++) begin : g_cmp
        tmr_cmp_delay #(.LAT(MATCH_LAT)) u_dly (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .match_i (cmp_match[g]),
            .force_i (cmp_force[g]),
            .set_o   (set_v[g+1])
        );
    end

    assign clr_v = ({NF{wr_en}} & wr_data) | ack;

    for (genvar f = 0; f < int'(NF); f++) begin : g_flag
        tmr_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[f]),
            .clr_i (clr_v[f]),
            .q_o   (flag_rd[f])
        );
    end

    assign irq_req = flag_rd & irq_en & {NF{gie}};

    tmr_irq_pick #(.N(NF), .ID_W(ID_W)) u_pick (
        .pend_i (irq_req),
        .any_o  (irq_any),
        .id_o   (irq_id)
    );
endmodule

// File: rtl/tmr_irq_flags_chk.sv
`timescale 1ns/1ps
module tmr_irq_flags_chk #(
    parameter int unsigned NF   = 4,
    parameter int unsigned ID_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            tick,
    input logic            top_hit,
    input logic            cap_is_top,
    input logic            ovf_evt,
    input logic            wr_en,
    input logic [NF-1:0]   wr_data,
    input logic [NF-1:0]   ack,
    input logic            gie,
    input logic [NF-1:0]   flag_rd,
    input logic [NF-1:0]   irq_req,
    input logic            irq_any,
    input logic [ID_W-1:0] irq_id
);
    // R1: the cycle after reset shows an empty flag register
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag_rd == '0));

    for (genvar i = 0; i < int'(NF); i++) begin : g_bit
        // R2: a flag can only rise on the edge of a tick cycle
        p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_rd[i]) |-> $past(tick));
        // R6: without a clear, a set flag stays set
        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (flag_rd[i] && !(wr_en && wr_data[i]) && !ack[i]) |=> flag_rd[i]);
    end

    // R4: TOP reached sets capture flag when capture register is TOP
    p_cap_top_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && cap_is_top && top_hit) |=> flag_rd[0]);

    // R6: write-one clears capture flag when no set can occur
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[0] && !tick) |=> !flag_rd[0]);

    // R7: acknowledge clears overflow flag when no set can occur
    p_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (ack[NF-1] && !tick) |=> !flag_rd[NF-1]);

    // R8: overflow set beats any clear in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && ovf_evt) |=> flag_rd[NF-1]);

    // R9: no request without global enable
    p_gie_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (|irq_req) |-> gie);

    // R10: the reported index is an active request with none below it
    p_pick_valid_r10: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> irq_req[irq_id]);
    p_pick_lowest_r10: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> ((irq_req & ((NF'(1) << irq_id) - NF'(1))) == '0));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.NF(NF), .ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .top_hit    (top_hit),
    .cap_is_top (cap_is_top),
    .ovf_evt    (ovf_evt),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ack        (ack),
    .gie        (gie),
    .flag_rd    (flag_rd),
    .irq_req    (irq_req),
    .irq_any    (irq_any),
    .irq_id     (irq_id)
);

// File: tb/sim_tmr_irq_flags.sv
`timescale 1ns/1ps
module sim_tmr_irq_flags;
    localparam int NF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [1:0] cmp_match = '0, cmp_force = '0;
    logic cap_evt = 1'b0, top_hit = 1'b0, cap_is_top = 1'b0, ovf_evt = 1'b0;
    logic wr_en = 1'b0;
    logic [NF-1:0] wr_data = '0, ack = '0, irq_en = '0;
    logic gie = 1'b0;
    logic [NF-1:0] flag_rd, irq_req;
    logic irq_any;
    logic [1:0] irq_id;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmr_irq_flags u0 (
        .clk(clk), .rst(rst), .tick(tick), .cmp_match(cmp_match),
        .cmp_force(cmp_force), .cap_evt(cap_evt), .top_hit(top_hit),
        .cap_is_top(cap_is_top), .ovf_evt(ovf_evt), .wr_en(wr_en),
        .wr_data(wr_data), .ack(ack), .irq_en(irq_en), .gie(gie),
        .flag_rd(flag_rd), .irq_req(irq_req), .irq_any(irq_any), .irq_id(irq_id)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tick = 0; cmp_match = 0; cmp_force = 0; cap_evt = 0; top_hit = 0;
        ovf_evt = 0; wr_en = 0; wr_data = 0; ack = 0;
    endtask

    task automatic clear_all();
        idle(); wr_en = 1; wr_data = '1; cyc(); idle();
    endtask

    // flag pattern: bit0 capture, bit1 cmp A, bit2 cmp B, bit3 overflow
    task automatic load(input logic [NF-1:0] p);
        clear_all();
        cap_is_top = 0;
        tick = 1; cap_evt = p[0]; cmp_match = p[2:1]; ovf_evt = p[3]; cyc();
        idle(); tick = 1; cyc(); idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) cyc();
        rst = 0;
        // R1 reset state
        check("R1 flags", int'(flag_rd), 0);
        check("R1 req", int'({irq_req, irq_any, irq_id}), 0);

        // R2 compare latency with gaps between ticks
        tick = 1; cmp_match = 2'b01; cyc(); idle();
        check("R2 no flag on match tick", int'(flag_rd[1]), 0);
        repeat (3) cyc();
        check("R2 no flag in gap", int'(flag_rd[1]), 0);
        tick = 1; cyc(); idle();
        check("R2 flag on next tick", int'(flag_rd[1]), 1);
        clear_all();
        // R2 events without tick ignored
        cmp_match = 2'b11; cap_evt = 1; ovf_evt = 1; cyc(); idle();
        tick = 1; cyc(); idle();
        check("R2 no tick no effect", int'(flag_rd), 0);

        // R3 forced compare suppressed, per channel
        tick = 1; cmp_match = 2'b11; cmp_force = 2'b10; cyc(); idle();
        tick = 1; cyc(); idle();
        check("R3 forced B suppressed", int'(flag_rd), 2);
        clear_all();

        // R4 capture source select
        cap_is_top = 0; tick = 1; top_hit = 1; cyc(); idle();
        check("R4 top ignored", int'(flag_rd[0]), 0);
        tick = 1; cap_evt = 1; cyc(); idle();
        check("R4 pin sets", int'(flag_rd[0]), 1);
        clear_all();
        cap_is_top = 1; tick = 1; cap_evt = 1; cyc(); idle();
        check("R4 pin ignored", int'(flag_rd[0]), 0);
        tick = 1; top_hit = 1; cyc(); idle();
        check("R4 top sets", int'(flag_rd[0]), 1);
        cap_is_top = 0;
        clear_all();

        // R5 overflow
        tick = 1; ovf_evt = 1; cyc(); idle();
        check("R5 overflow", int'(flag_rd), 8);

        // R6 write-one-to-clear sweep, R7 acknowledge sweep
        for (int w = 0; w < 16; w++) begin
            load(4'hF);
            wr_en = 1; wr_data = 4'(w); cyc(); idle();
            check("R6 w1c", int'(flag_rd), 15 & ~w);
            load(4'hF);
            ack = 4'(w); cyc(); idle();
            check("R7 ack", int'(flag_rd), 15 & ~w);
        end

        // R8 set wins over clear
        clear_all();
        tick = 1; cap_evt = 1; wr_en = 1; wr_data = 4'h1; cyc(); idle();
        check("R8 capture vs write", int'(flag_rd[0]), 1);
        tick = 1; ovf_evt = 1; ack = 4'h8; cyc(); idle();
        check("R8 overflow vs ack", int'(flag_rd[3]), 1);
        tick = 1; cmp_match = 2'b01; cyc(); idle();
        tick = 1; wr_en = 1; wr_data = 4'h2; ack = 4'h2; cyc(); idle();
        check("R8 compare vs clears", int'(flag_rd[1]), 1);

        // R9 / R10 sweep of flags x enables x global enable
        for (int f = 0; f < 16; f++) begin
            load(4'(f));
            check("R6 load pattern", int'(flag_rd), f);
            for (int e = 0; e < 16; e++) begin
                for (int g = 0; g < 2; g++) begin
                    int exp_req;
                    int exp_id;
                    irq_en = 4'(e); gie = g[0];
                    #1;
                    exp_req = (g == 1) ? (f & e) : 0;
                    exp_id = 0;
                    for (int b = 3; b >= 0; b--) if (exp_req[b]) exp_id = b;
                    check("R9 req", int'(irq_req), exp_req);
                    check("R9 any", int'(irq_any), int'(exp_req != 0));
                    check("R10 id", int'(irq_id), exp_id);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule